// File: doc/BRIEF.md
# Power-Down and Wake-Up Sequencer

This block governs how a device enters and leaves its deep power-down state. Software sets a single request bit. The block then waits a fixed number of core clock cycles before it raises the power-down signal. That delay gives the program time to execute its own halt. While power-down is active, the block forces off every gated domain and stops the clock subsystem: the analog block, the supply-fault detector, the analog comparator, the high-speed oscillator, the card supply and the flash read one-shot.

Leaving power-down needs a wake request, which is the OR of a group of user interrupt lines, a card event and a keypad event. The block accepts that request only if the wake-path enable was set when the power-down was requested. An accepted wake drops the power-down signal at once, which restores all domains and the clock subsystem. The block then waits until the clocks report that they are running and counts a fixed number of running cycles. Only after that does it raise the core's interrupt-0 line. The interrupt stays latched until software acknowledges it, and the request bit clears itself at that point.

When no power-down is pending, the wake sources drive interrupt-0 directly with no delay. A wake that arrives during the entry delay cancels the entry.

Top module: `pd_wake_seq`

## Requirements
- R1: After a `pd_req_wr` pulse sampled in the running state, `pd_req_bit` is high after that clock edge, and `pd_active` rises exactly 32 rising edges later (`ENTRY_DLY`).
- R2: While `pd_active` is high, all six `gate_*` outputs and `clk_sys_en` are low. Otherwise each `gate_*` output equals its `en_*` input and `clk_sys_en` is high.
- R3: Only the request bit leads to power-down. Clearing any or all `en_*` inputs leaves `pd_active` low, and a `pd_req_wr` pulse is ignored while an entry, power-down or wake sequence is in progress.
- R4: The wake request is the OR of every bit of `wake_user`, `wake_card` and `wake_keypad`. Any single source is enough.
- R5: The value of `wake_mux_en` is captured when the request is accepted. If it was low, wake requests during power-down are ignored and `pd_active` stays high.
- R6: An accepted wake during power-down drops `pd_active` on the next rising edge, which restores the gates and `clk_sys_en`.
- R7: After release, `int0` stays low until the 512th consecutive rising edge (`WAKE_DLY`) at which `clk_running` is sampled high, and rises right after that edge. A low sample of `clk_running` restarts the count.
- R8: A wake request during the entry delay cancels the entry. `pd_active` never rises, `pd_req_bit` clears on the next edge, and `int0` follows the wake sources in the same cycle.
- R9: At the end of the wake count, `pd_req_bit` clears. `int0` then stays high until an `int_ack` pulse is sampled, after which it follows the pass-through path.
- R10: In the running state, `int0` is high in the same cycle as any wake source with no register delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pd_req_wr | input | 1 | Software pulse that sets the power-down request bit |
| int_ack | input | 1 | Software pulse that clears the latched wake interrupt |
| wake_mux_en | input | 1 | Enables the wake path; captured when the request is accepted |
| wake_user | input | USER_W | User interrupt wake group |
| wake_card | input | 1 | Card event wake source |
| wake_keypad | input | 1 | Keypad event wake source |
| clk_running | input | 1 | High while the clock subsystem delivers a stable clock |
| en_analog | input | 1 | Enable for the analog block (VCO, PLL, reference, bias) |
| en_fault_det | input | 1 | Enable for the supply-fault detector |
| en_cmp | input | 1 | Enable for the analog comparator |
| en_hosc | input | 1 | Enable for the high-speed oscillator |
| en_card_pwr | input | 1 | Enable for the card supply |
| en_flash_pulse | input | 1 | Enable for the flash read one-shot |
| pd_active | output | 1 | Delayed power-down signal |
| clk_sys_en | output | 1 | Clock subsystem enable |
| gate_analog | output | 1 | Gated analog enable |
| gate_fault_det | output | 1 | Gated fault-detector enable |
| gate_cmp | output | 1 | Gated comparator enable |
| gate_hosc | output | 1 | Gated oscillator enable |
| gate_card_pwr | output | 1 | Gated card supply enable |
| gate_flash_pulse | output | 1 | Gated flash one-shot enable |
| pd_req_bit | output | 1 | Request bit; self-clears when the sequence completes or is cancelled |
| int0 | output | 1 | Wake interrupt to the core |

## Verification
A wrong count in the entry counter moves the rising edge of `pd_active`, and every gate output and `clk_sys_en` then flips in the wrong cycle. A cycle-by-cycle comparison catches this within one cycle of the expected edge. A wake counter that misses a restart, or ignores `clk_running`, raises `int0` early or late, and the mismatch shows up about 512 cycles after release. A wrong state or a lost captured wake-path enable shows up at once as a `pd_active` that does not fall, or that falls when it should stay high, on the edge after a wake source is applied.

// File: rtl/pd_wake_seq.sv
module pd_wake_seq #(
  parameter int ENTRY_DLY = 32,
  parameter int WAKE_DLY  = 512,
  parameter int USER_W    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pd_req_wr,
  input  logic              int_ack,
  input  logic              wake_mux_en,
  input  logic [USER_W-1:0] wake_user,
  input  logic              wake_card,
  input  logic              wake_keypad,
  input  logic              clk_running,
  input  logic              en_analog,
  input  logic              en_fault_det,
  input  logic              en_cmp,
  input  logic              en_hosc,
  input  logic              en_card_pwr,
  input  logic              en_flash_pulse,
  output logic              pd_active,
  output logic              clk_sys_en,
  output logic              gate_analog,
  output logic              gate_fault_det,
  output logic              gate_cmp,
  output logic              gate_hosc,
  output logic              gate_card_pwr,
  output logic              gate_flash_pulse,
  output logic              pd_req_bit,
  output logic              int0
);

  localparam int MAXDLY = (ENTRY_DLY > WAKE_DLY) ? ENTRY_DLY : WAKE_DLY;
  localparam int CW     = $clog2(MAXDLY + 1);

  typedef enum logic [1:0] {S_RUN, S_ENTRY, S_DOWN, S_WAKE} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic          mux_lat;
  logic          req_q;
  logic          int_lat;

  wire wake_any   = (|wake_user) | wake_card | wake_keypad;
  wire entry_done = (st == S_ENTRY) && !wake_any && (cnt == CW'(ENTRY_DLY - 1));
  wire wake_done  = (st == S_WAKE) && clk_running && (cnt == CW'(WAKE_DLY - 1));
  wire passthru   = (st == S_RUN) || (st == S_ENTRY);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_RUN;
      cnt     <= '0;
      mux_lat <= 1'b0;
      req_q   <= 1'b0;
    end else begin
      case (st)
        S_RUN: if (pd_req_wr) begin
          st      <= S_ENTRY;
          cnt     <= '0;
          req_q   <= 1'b1;
          mux_lat <= wake_mux_en;
        end
        S_ENTRY: begin
          if (wake_any) begin
            st    <= S_RUN;
            cnt   <= '0;
            req_q <= 1'b0;
          end else if (entry_done) begin
            st  <= S_DOWN;
            cnt <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_DOWN: if (wake_any && mux_lat) begin
          st  <= S_WAKE;
          cnt <= '0;
        end
        S_WAKE: begin
          if (!clk_running) begin
            cnt <= '0;
          end else if (wake_done) begin
            st    <= S_RUN;
            cnt   <= '0;
            req_q <= 1'b0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: st <= S_RUN;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         int_lat <= 1'b0;
    else if (wake_done) int_lat <= 1'b1;
    else if (int_ack)   int_lat <= 1'b0;
  end

  assign pd_active        = (st == S_DOWN);
  assign clk_sys_en       = !pd_active;
  assign gate_analog      = en_analog      & ~pd_active;
  assign gate_fault_det   = en_fault_det   & ~pd_active;
  assign gate_cmp         = en_cmp         & ~pd_active;
  assign gate_hosc        = en_hosc        & ~pd_active;
  assign gate_card_pwr    = en_card_pwr    & ~pd_active;
  assign gate_flash_pulse = en_flash_pulse & ~pd_active;
  assign pd_req_bit       = req_q;
  assign int0             = int_lat | (passthru & wake_any);

  logic [CW:0] ent_seen;
  logic [CW:0] run_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ent_seen <= '0;
      run_seen <= '0;
    end else begin
      ent_seen <= (st == S_ENTRY) ? ent_seen + 1'b1 : '0;
      run_seen <= (st == S_WAKE && clk_running) ? run_seen + 1'b1 : '0;
    end
  end

  p_entry_delay_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pd_active) |-> ent_seen == (CW+1)'(ENTRY_DLY));

  p_only_by_request_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pd_active) |-> req_q);

  p_mux_block_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_active && !mux_lat) |=> pd_active);

  p_wake_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_active && wake_any && mux_lat) |=> !pd_active);

  p_wake_count_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(int_lat) && $past(st) == S_WAKE) |-> run_seen == (CW+1)'(WAKE_DLY));

  p_quiet_down_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_active && !int_lat) |-> !int0);

  p_abort_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(st) == S_ENTRY && $past(wake_any)) |-> (!pd_active && !req_q));

  p_int_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (int_lat && !int_ack) |=> int0);

endmodule

// File: tb/pd_wake_seq_bench.sv
module pd_wake_seq_bench;
  localparam int ENTRY = 32;
  localparam int WAKE  = 512;

  logic clk = 0;
  logic rst_n = 0;
  logic pd_req_wr = 0, int_ack = 0, wake_mux_en = 1;
  logic [7:0] wake_user = 0;
  logic wake_card = 0, wake_keypad = 0, clk_running = 0;
  logic [5:0] en = 6'b111111;
  logic pd_active, clk_sys_en, pd_req_bit, int0;
  logic [5:0] gates;
  bit glitch = 0;

  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  pd_wake_seq u_pd_wake_seq (
    .clk(clk), .rst_n(rst_n), .pd_req_wr(pd_req_wr), .int_ack(int_ack),
    .wake_mux_en(wake_mux_en), .wake_user(wake_user), .wake_card(wake_card),
    .wake_keypad(wake_keypad), .clk_running(clk_running),
    .en_analog(en[0]), .en_fault_det(en[1]), .en_cmp(en[2]), .en_hosc(en[3]),
    .en_card_pwr(en[4]), .en_flash_pulse(en[5]),
    .pd_active(pd_active), .clk_sys_en(clk_sys_en),
    .gate_analog(gates[0]), .gate_fault_det(gates[1]), .gate_cmp(gates[2]),
    .gate_hosc(gates[3]), .gate_card_pwr(gates[4]), .gate_flash_pulse(gates[5]),
    .pd_req_bit(pd_req_bit), .int0(int0)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // clock subsystem model: stable some cycles after enable
  int run_wait = 0;
  always @(posedge clk) begin
    #1;
    if (!clk_sys_en) begin run_wait = 0; clk_running = 0; end
    else if (glitch) clk_running = 0;
    else if (run_wait < 5) run_wait++;
    else clk_running = 1;
  end

  // behavioural reference: 0 run, 1 entry, 2 down, 3 wake
  int ph = 0, t = 0, r = 0;
  bit mreq = 0, mlat = 0, mmux = 0;
  always @(posedge clk) begin
    bit wk, done;
    wk = (wake_user != 0) || wake_card || wake_keypad;
    done = 0;
    if (!rst_n) begin
      ph = 0; t = 0; r = 0; mreq = 0; mlat = 0; mmux = 0;
    end else begin
      case (ph)
        0: if (pd_req_wr) begin ph = 1; t = 0; mreq = 1; mmux = wake_mux_en; end
        1: if (wk) begin ph = 0; mreq = 0; end
           else begin t++; if (t == ENTRY) ph = 2; end
        2: if (wk && mmux) begin ph = 3; r = 0; end
        default: begin
          if (clk_running) r++; else r = 0;
          if (r == WAKE) begin ph = 0; mreq = 0; done = 1; end
        end
      endcase
      if (done) mlat = 1; else if (int_ack) mlat = 0;
    end
    #3;
    if (rst_n) begin
      bit epd, eint;
      epd  = (ph == 2);
      eint = mlat || ((ph <= 1) && ((wake_user != 0) || wake_card || wake_keypad));
      chk(pd_active == epd, "R1 pd_active", pd_active, epd);
      chk(clk_sys_en == !epd, "R2 clk_sys_en", clk_sys_en, !epd);
      chk(gates == (epd ? 6'b0 : en), "R2 gates", gates, epd ? 0 : en);
      chk(pd_req_bit == mreq, "R9 pd_req_bit", pd_req_bit, mreq);
      chk(int0 == eint, "R7 int0", int0, eint);
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic request();
    pd_req_wr = 1; tick(1); pd_req_wr = 0;
  endtask

  task automatic ack();
    int_ack = 1; tick(1); int_ack = 0;
  endtask

  task automatic wait_int(input int lim, output int k);
    k = 0;
    while (!int0 && k < lim) begin tick(1); k++; end
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int k;
    tick(3); rst_n = 1; tick(2);
    chk(!pd_active && clk_sys_en && !int0 && !pd_req_bit, "R2 reset state", pd_active, 0);

    // R10 pass-through
    wake_user = 8'h08; #1;
    chk(int0 == 1, "R10 user passthru", int0, 1);
    wake_user = 0; #1;
    chk(int0 == 0, "R10 passthru release", int0, 0);
    tick(2);

    // R3 clearing enables does not power down
    en = 6'b0; tick(40);
    chk(!pd_active && gates == 0 && clk_sys_en, "R3 enables cleared", pd_active, 0);
    en = 6'b101101; tick(2);
    chk(gates == 6'b101101, "R2 gates follow", gates, 6'b101101);
    en = 6'b111111;

    // R1 entry delay, then R4/R6 wake by card, R7 with glitch, R9
    wake_mux_en = 1;
    request();
    chk(pd_req_bit == 1, "R1 request bit set", pd_req_bit, 1);
    k = 0;
    while (!pd_active && k < 100) begin tick(1); k++; end
    chk(k == ENTRY, "R1 entry delay", k, ENTRY);
    chk(gates == 0 && !clk_sys_en, "R2 gates off", gates, 0);
    request(); tick(3);
    chk(pd_active == 1, "R3 request ignored in down", pd_active, 1);
    wake_card = 1; tick(1); wake_card = 0;
    chk(!pd_active && clk_sys_en, "R6 card wake release", pd_active, 0);
    while (!clk_running) tick(1);
    tick(100); glitch = 1; tick(1); glitch = 0;
    tick(400);
    chk(int0 == 0 && pd_req_bit == 1, "R7 glitch restarts count", int0, 0);
    wait_int(1000, k);
    chk(int0 == 1 && pd_req_bit == 0, "R9 bit cleared at wake", pd_req_bit, 0);
    tick(20);
    chk(int0 == 1, "R9 int0 held", int0, 1);
    ack();
    chk(int0 == 0, "R9 ack clears", int0, 0);
    tick(3);

    // R7 exact count, R4 keypad and user sources
    for (int s = 0; s < 2; s++) begin
      request(); tick(ENTRY + 2);
      chk(pd_active == 1, "R1 down again", pd_active, 1);
      if (s == 0) wake_keypad = 1; else wake_user = 8'h80;
      tick(1); wake_keypad = 0; wake_user = 0;
      chk(pd_active == 0, "R4 source wakes", pd_active, 0);
      while (!clk_running) tick(1);
      wait_int(2000, k);
      chk(k == WAKE, "R7 wake delay", k, WAKE);
      ack(); tick(2);
    end

    // R8 abort during entry
    request(); tick(10);
    wake_keypad = 1; #1;
    chk(int0 == 1, "R8 abort passthru", int0, 1);
    tick(1); wake_keypad = 0;
    chk(pd_req_bit == 0, "R8 request cleared", pd_req_bit, 0);
    tick(40);
    chk(pd_active == 0, "R8 never down", pd_active, 0);

    // R5 wake path disabled at request
    wake_mux_en = 0;
    request(); wake_mux_en = 1; tick(ENTRY + 2);
    chk(pd_active == 1, "R5 down", pd_active, 1);
    wake_card = 1; wake_user = 8'hFF; tick(5); wake_card = 0; wake_user = 0;
    tick(50);
    chk(pd_active == 1 && int0 == 0, "R5 wake ignored", pd_active, 1);
    rst_n = 0; tick(2); rst_n = 1; tick(2);
    chk(!pd_active && !pd_req_bit, "R2 recovered", pd_active, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule